// File: doc/BRIEF.md
# Video Encoder Control Register Bank with Pin Readback

This block is the register bank behind a video encoder's control interface. A host reaches it through a simple parallel register bus made of an address, write data, a write strobe, a read strobe and registered read data. The bank holds a mode register whose lowest bit puts the encoder into sleep, and a small set of general configuration registers that feed the rest of the encoder. It also has a soft-reset bit that clears itself.

In sleep, the bank substitutes fixed levels for the encoder's pixel, sync, blanking, lock and pixel-strobe inputs before they reach the encoder core. It also drops the enable of the encoder's output drivers so that those pins float. The register bus itself stays live during sleep. For board-level connectivity tests, the bank keeps read-only copies of the levels on the three pixel ports and the six control pins. A copy is taken on every cycle in which the pixel strobe is active and the part is awake.

The pixel clock is brought in as a strobe `pix_strobe`, qualified in the bank's own clock domain. A captured level therefore changes only while that strobe keeps pulsing.

Top module: `vid_ctl_bank`

## Requirements
- R1: After the synchronous reset `rst`, the mode register at address 0x00 reads 0x00. Configuration register k (address 0x01+k, k = 0..NCFG-1) reads 0xA1+k. All readback registers read 0x00, and `drv_oe` is 1.
- R2: A write to address 0x00 or to a configuration address stores the full byte. A read strobe at clock edge N presents that register on `bus_rdata` from edge N, and `bus_rdata` holds that value until the next read strobe.
- R3: Bit 0 of address 0x00 is the sleep control. A 1 written there makes `drv_oe` 0 from the clock edge that takes the write. A 0 written there makes it 1 again.
- R4: In sleep, `core_pix` and `core_strobe` are 0 and `core_ctl` is all ones, whatever the pins carry. When awake, `core_pix` = {pix_c, pix_b, pix_a} and `core_ctl` = {lock_in, blank_in, vsync_b, hsync_b, vsync_a, hsync_a}, where each vsync/hsync pair belongs to one of the two sync ports.
- R5: Register reads and writes work normally while in sleep.
- R6: Writing a byte with bit 1 set to address 0x17 returns the mode register and all configuration registers to their R1 values on the following clock edge. This also leaves sleep. A write to 0x17 with bit 1 clear changes nothing.
- R7: The soft-reset bit (address 0x17, bit 1) clears itself one cycle after the write. From then on, address 0x17 reads 0x00.
- R8: Readback registers map as follows. 0x12 holds pix_a, 0x13 holds pix_b and 0x14 holds pix_c. 0x16 holds {2'b00, lock_in, blank_in, vsync_b, hsync_b, vsync_a, hsync_a}.
- R9: Readback registers capture the pins only at clock edges where `pix_strobe` is 1 and the part is awake. At any other edge they hold their value.
- R10: Writes to readback addresses leave the readback contents unchanged.
- R11: Reads of any address other than 0x00, 0x01..0x00+NCFG, 0x12, 0x13, 0x14, 0x16 and 0x17 return 0x00.
- R12: A soft reset leaves the readback registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | AW | Register address |
| bus_wdata | input | DW | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DW | Registered read data |
| pix_strobe | input | 1 | Pixel clock strobe |
| pix_a | input | DW | Pixel port A pins |
| pix_b | input | DW | Pixel port B pins |
| pix_c | input | DW | Pixel port C pins |
| hsync_a | input | 1 | Horizontal sync, port A |
| vsync_a | input | 1 | Vertical sync, port A |
| hsync_b | input | 1 | Horizontal sync, port B |
| vsync_b | input | 1 | Vertical sync, port B |
| blank_in | input | 1 | Blanking input |
| lock_in | input | 1 | Subcarrier lock pin |
| core_pix | output | 3*DW | Gated pixel data to the encoder core |
| core_ctl | output | 6 | Gated control pins to the encoder core |
| core_strobe | output | 1 | Gated pixel strobe to the encoder core |
| drv_oe | output | 1 | Enable for the encoder's output drivers |
| cfg_out | output | NCFG*DW | Configuration registers, register k at bits k*DW upward |

## Verification
The bench drives inputs on the falling edge and samples on the next falling edge, so each registered result is read half a cycle after the rising edge that produces it. Read data, the `drv_oe` change after a sleep write, and a readback capture after a one-cycle strobe are all due one edge after the stimulus. The gated core signals are combinational from the stored sleep bit and are checked in the same half cycle as the pin change. A soft reset needs two edges: one to latch the bit and one to apply the defaults. The bench therefore lets one idle cycle pass before it reads back. The whole address space is swept after reset, and the expected register image is kept arithmetically in the bench.

// File: rtl/vctl_pkg.sv
package vctl_pkg;
  localparam logic [7:0] A_MODE   = 8'h00;
  localparam logic [7:0] A_CFG0   = 8'h01;
  localparam logic [7:0] A_RB_A   = 8'h12;
  localparam logic [7:0] A_RB_B   = 8'h13;
  localparam logic [7:0] A_RB_C   = 8'h14;
  localparam logic [7:0] A_RB_CTL = 8'h16;
  localparam logic [7:0] A_SRST   = 8'h17;
  localparam int SLEEP_BIT = 0;
  localparam int SRST_BIT  = 1;
  localparam int CTL_W     = 6;
  localparam logic [7:0] MODE_DEF = 8'h00;

  typedef struct packed {
    logic lock;
    logic blank;
    logic vs_b;
    logic hs_b;
    logic vs_a;
    logic hs_a;
  } ctl_pins_t;

  function automatic logic [7:0] cfg_default(input int k);
    return 8'hA1 + 8'(k);
  endfunction

  function automatic logic is_mapped(input int a, input int ncfg);
    return (a == int'(A_MODE)) || (a >= int'(A_CFG0) && a < int'(A_CFG0) + ncfg) ||
           (a == int'(A_RB_A)) || (a == int'(A_RB_B)) || (a == int'(A_RB_C)) ||
           (a == int'(A_RB_CTL)) || (a == int'(A_SRST));
  endfunction
endpackage

// File: rtl/vctl_regs.sv
module vctl_regs
  import vctl_pkg::*;
#(
  parameter int AW   = 8,
  parameter int DW   = 8,
  parameter int NCFG = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr,
  input  logic [AW-1:0]           addr,
  input  logic [DW-1:0]           wdata,
  output logic [DW-1:0]           mode_q,
  output logic [NCFG-1:0][DW-1:0] cfg_q,
  output logic                    srst_q
);
  logic hit_mode, hit_srst;
  assign hit_mode = wr && (addr == AW'(A_MODE));
  assign hit_srst = wr && (addr == AW'(A_SRST)) && wdata[SRST_BIT];

  always_ff @(posedge clk) begin
    if (rst || srst_q) begin
      mode_q <= DW'(MODE_DEF);
      srst_q <= 1'b0;
    end else begin
      srst_q <= hit_srst;
      if (hit_mode) mode_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < NCFG; k++) begin
      if (rst || srst_q)
        cfg_q[k] <= DW'(cfg_default(k));
      else if (wr && (addr == AW'(int'(A_CFG0) + k)))
        cfg_q[k] <= wdata;
    end
  end

  // R7: soft-reset bit never stays set for two cycles
  p_srst_self_clear_r7: assert property (@(posedge clk) disable iff (rst)
    srst_q |=> !srst_q);
  // R6: one cycle after the soft-reset bit is seen, the mode register holds its default
  p_srst_defaults_r6: assert property (@(posedge clk) disable iff (rst)
    srst_q |=> (mode_q == DW'(MODE_DEF)));
endmodule

// File: rtl/vctl_pins.sv
module vctl_pins
  import vctl_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sleep,
  input  logic            pix_strobe,
  input  logic [DW-1:0]   pix_a,
  input  logic [DW-1:0]   pix_b,
  input  logic [DW-1:0]   pix_c,
  input  ctl_pins_t       ctl_in,
  output logic [3*DW-1:0] core_pix,
  output ctl_pins_t       core_ctl,
  output logic            core_strobe,
  output logic [DW-1:0]   rb_a,
  output logic [DW-1:0]   rb_b,
  output logic [DW-1:0]   rb_c,
  output ctl_pins_t       rb_ctl
);
  // Sleep ties data and strobe low, control pins (active-low syncs) high
  assign core_pix    = sleep ? '0 : {pix_c, pix_b, pix_a};
  assign core_ctl    = sleep ? '1 : ctl_in;
  assign core_strobe = pix_strobe & ~sleep;

  always_ff @(posedge clk) begin
    if (rst) begin
      rb_a   <= '0;
      rb_b   <= '0;
      rb_c   <= '0;
      rb_ctl <= '0;
    end else if (core_strobe) begin
      rb_a   <= pix_a;
      rb_b   <= pix_b;
      rb_c   <= pix_c;
      rb_ctl <= ctl_in;
    end
  end

  // R9: no capture without an awake pixel strobe
  p_hold_no_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    !(pix_strobe && !sleep) |=> ($stable(rb_a) && $stable(rb_b) && $stable(rb_c) && $stable(rb_ctl)));
endmodule

// File: rtl/vctl_rdmux.sv
module vctl_rdmux
  import vctl_pkg::*;
#(
  parameter int AW   = 8,
  parameter int DW   = 8,
  parameter int NCFG = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    rd,
  input  logic [AW-1:0]           addr,
  input  logic [DW-1:0]           mode_q,
  input  logic [NCFG-1:0][DW-1:0] cfg_q,
  input  logic                    srst_q,
  input  logic [DW-1:0]           rb_a,
  input  logic [DW-1:0]           rb_b,
  input  logic [DW-1:0]           rb_c,
  input  ctl_pins_t               rb_ctl,
  output logic [DW-1:0]           rdata
);
  logic [DW-1:0] nxt;

  always_comb begin
    nxt = '0;
    for (int k = 0; k < NCFG; k++)
      if (addr == AW'(int'(A_CFG0) + k)) nxt = cfg_q[k];
    if (addr == AW'(A_MODE))   nxt = mode_q;
    if (addr == AW'(A_RB_A))   nxt = rb_a;
    if (addr == AW'(A_RB_B))   nxt = rb_b;
    if (addr == AW'(A_RB_C))   nxt = rb_c;
    if (addr == AW'(A_RB_CTL)) nxt = DW'(rb_ctl);
    if (addr == AW'(A_SRST))   nxt[SRST_BIT] = srst_q;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= nxt;
  end

  // R11: unmapped addresses read as zero
  p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (rd && !is_mapped(int'(addr), NCFG)) |=> (rdata == '0));
endmodule

// File: rtl/vid_ctl_bank.sv
module vid_ctl_bank
  import vctl_pkg::*;
#(
  parameter int AW   = 8,
  parameter int DW   = 8,
  parameter int NCFG = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DW-1:0]     bus_rdata,
  input  logic              pix_strobe,
  input  logic [DW-1:0]     pix_a,
  input  logic [DW-1:0]     pix_b,
  input  logic [DW-1:0]     pix_c,
  input  logic              hsync_a,
  input  logic              vsync_a,
  input  logic              hsync_b,
  input  logic              vsync_b,
  input  logic              blank_in,
  input  logic              lock_in,
  output logic [3*DW-1:0]   core_pix,
  output logic [CTL_W-1:0]  core_ctl,
  output logic              core_strobe,
  output logic              drv_oe,
  output logic [NCFG*DW-1:0] cfg_out
);
  logic [DW-1:0]           mode_q;
  logic [NCFG-1:0][DW-1:0] cfg_q;
  logic                    srst_q;
  logic                    sleep;
  logic [DW-1:0]           rb_a, rb_b, rb_c;
  ctl_pins_t               rb_ctl, ctl_in, ctl_g;

  assign ctl_in  = '{lock: lock_in, blank: blank_in, vs_b: vsync_b,
                     hs_b: hsync_b, vs_a: vsync_a, hs_a: hsync_a};
  assign sleep   = mode_q[SLEEP_BIT];
  assign drv_oe  = ~sleep;
  assign cfg_out = cfg_q;
  assign core_ctl = ctl_g;

  vctl_regs #(.AW(AW), .DW(DW), .NCFG(NCFG)) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .mode_q(mode_q), .cfg_q(cfg_q), .srst_q(srst_q));

  vctl_pins #(.DW(DW)) u_pins (
    .clk(clk), .rst(rst), .sleep(sleep), .pix_strobe(pix_strobe),
    .pix_a(pix_a), .pix_b(pix_b), .pix_c(pix_c), .ctl_in(ctl_in),
    .core_pix(core_pix), .core_ctl(ctl_g), .core_strobe(core_strobe),
    .rb_a(rb_a), .rb_b(rb_b), .rb_c(rb_c), .rb_ctl(rb_ctl));

  vctl_rdmux #(.AW(AW), .DW(DW), .NCFG(NCFG)) u_rdmux (
    .clk(clk), .rst(rst), .rd(bus_rd), .addr(bus_addr), .mode_q(mode_q),
    .cfg_q(cfg_q), .srst_q(srst_q), .rb_a(rb_a), .rb_b(rb_b), .rb_c(rb_c),
    .rb_ctl(rb_ctl), .rdata(bus_rdata));

  // R3: a write of 1 to the sleep bit drops the driver enable at the next edge
  p_sleep_entry_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == AW'(A_MODE) && bus_wdata[SLEEP_BIT] && !srst_q) |=> !drv_oe);
endmodule

// File: tb/test_vid_ctl_bank.sv
`timescale 1ns/1ps
module test_vid_ctl_bank;
  localparam int AW = 8, DW = 8, NCFG = 4;

  logic clk = 0, rst = 1;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic bus_wr = 0, bus_rd = 0;
  logic [DW-1:0] bus_rdata;
  logic pix_strobe = 0;
  logic [DW-1:0] pix_a = '0, pix_b = '0, pix_c = '0;
  logic hsync_a = 0, vsync_a = 0, hsync_b = 0, vsync_b = 0, blank_in = 0, lock_in = 0;
  logic [3*DW-1:0] core_pix;
  logic [5:0] core_ctl;
  logic core_strobe, drv_oe;
  logic [NCFG*DW-1:0] cfg_out;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0] e_mode;
  logic [7:0] e_cfg [NCFG];
  logic [7:0] e_ra, e_rb, e_rc, e_rctl;

  always #2.5 clk = ~clk;

  vid_ctl_bank #(.AW(AW), .DW(DW), .NCFG(NCFG)) i_vid_ctl_bank (.*);

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  function automatic logic [7:0] model_rd(input int a);
    if (a == 0) return e_mode;
    if (a >= 1 && a <= NCFG) return e_cfg[a-1];
    if (a == 8'h12) return e_ra;
    if (a == 8'h13) return e_rb;
    if (a == 8'h14) return e_rc;
    if (a == 8'h16) return e_rctl;
    return 8'h00;
  endfunction

  function automatic string tag_of(input int a);
    if (a == 8'h12 || a == 8'h13 || a == 8'h14 || a == 8'h16) return "R8";
    if (a == 0 || (a >= 1 && a <= NCFG)) return "R1";
    if (a == 8'h17) return "R7";
    return "R11";
  endfunction

  task automatic model_defaults();
    e_mode = 8'h00;
    for (int k = 0; k < NCFG; k++) e_cfg[k] = 8'hA1 + 8'(k);
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = AW'(a); bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
    if (a == 0) e_mode = d;
    if (a >= 1 && a <= NCFG) e_cfg[a-1] = d;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = AW'(a); bus_rd = 1;
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic rd_chk(input string req, input int a);
    logic [7:0] d;
    rd(a, d);
    chk(req, $sformatf("read %02h", a), 32'(d), 32'(model_rd(a)));
  endtask

  task automatic set_pins(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c, input logic [5:0] ctl);
    pix_a = a; pix_b = b; pix_c = c;
    {lock_in, blank_in, vsync_b, hsync_b, vsync_a, hsync_a} = ctl;
  endtask

  task automatic strobe_once();
    @(negedge clk);
    pix_strobe = 1;
    @(negedge clk);
    pix_strobe = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    model_defaults();
    e_ra = 0; e_rb = 0; e_rc = 0; e_rctl = 0;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state and full address sweep (R8, R11 layout)
    @(negedge clk);
    chk("R1", "drv_oe after reset", 32'(drv_oe), 1);
    chk("R1", "cfg_out after reset", 32'(cfg_out), 32'hA4A3A2A1);
    for (int a = 0; a < 256; a++) rd_chk(tag_of(a), a);

    // R2 write/read of mode and config registers
    wr(0, 8'h3C);
    for (int k = 0; k < NCFG; k++) wr(1 + k, 8'(k * 8'h11 + 8'h03));
    for (int a = 0; a <= NCFG; a++) rd_chk("R2", a);
    chk("R2", "cfg_out", 32'(cfg_out), {e_cfg[3], e_cfg[2], e_cfg[1], e_cfg[0]});
    chk("R3", "drv_oe awake with bit0 clear", 32'(drv_oe), 1);
    // R2: read data held without a read strobe
    rd(1, d);
    repeat (3) @(negedge clk);
    chk("R2", "rdata held", 32'(bus_rdata), 32'(e_cfg[0]));

    // R8/R4 readback patterns and passthrough when awake
    for (int p = 0; p < 6; p++) begin
      logic [7:0] v;
      v = 8'(p * 37 + 5);
      set_pins(v, ~v, v ^ 8'h55, v[5:0] ^ 6'(p));
      @(negedge clk);
      chk("R4", "core_pix awake", 32'(core_pix), 32'({v ^ 8'h55, ~v, v}));
      chk("R4", "core_ctl awake", 32'(core_ctl), 32'(v[5:0] ^ 6'(p)));
      strobe_once();
      e_ra = v; e_rb = ~v; e_rc = v ^ 8'h55; e_rctl = {2'b00, v[5:0] ^ 6'(p)};
      rd_chk("R8", 8'h12); rd_chk("R8", 8'h13); rd_chk("R8", 8'h14); rd_chk("R8", 8'h16);
      // R9: pins change without strobe, readback holds
      set_pins(~v, v, ~v, ~v[5:0]);
      repeat (2) @(negedge clk);
      rd_chk("R9", 8'h12); rd_chk("R9", 8'h16);
    end

    // R10 writes to readback addresses ignored; R11 unmapped write ignored
    wr(8'h12, 8'hFF); wr(8'h13, 8'hFF); wr(8'h14, 8'hFF); wr(8'h16, 8'hFF);
    rd_chk("R10", 8'h12); rd_chk("R10", 8'h13); rd_chk("R10", 8'h14); rd_chk("R10", 8'h16);
    wr(8'h05, 8'h77); rd_chk("R11", 8'h05);
    wr(8'h15, 8'h77); rd_chk("R11", 8'h15);

    // R3/R4 sleep entry
    wr(0, 8'h01);
    chk("R3", "drv_oe in sleep", 32'(drv_oe), 0);
    set_pins(8'hFF, 8'hFF, 8'hFF, 6'h00);
    pix_strobe = 1;
    @(negedge clk);
    chk("R4", "core_pix in sleep", 32'(core_pix), 0);
    chk("R4", "core_ctl in sleep", 32'(core_ctl), 32'h3F);
    chk("R4", "core_strobe in sleep", 32'(core_strobe), 0);
    @(negedge clk);
    pix_strobe = 0;
    // R9 no capture during sleep
    rd_chk("R9", 8'h12); rd_chk("R9", 8'h16);
    // R5 bus alive in sleep
    wr(2, 8'h5E); rd_chk("R5", 2); rd_chk("R5", 0);
    // R3 leave sleep
    wr(0, 8'h00);
    chk("R3", "drv_oe after wake", 32'(drv_oe), 1);
    chk("R4", "core_pix after wake", 32'(core_pix), 32'h00FFFFFF);
    chk("R4", "core_strobe after wake", 32'(core_strobe), 0);

    // R6 write to 0x17 with bit1 clear changes nothing
    wr(1, 8'h99); wr(0, 8'h3C);
    wr(8'h17, 8'hFD);
    @(negedge clk);
    rd_chk("R6", 0); rd_chk("R6", 1); rd_chk("R7", 8'h17);

    // R6/R7/R12 soft reset from sleep with fresh readback values
    set_pins(8'hC3, 8'h3C, 8'h81, 6'h2A);
    strobe_once();
    e_ra = 8'hC3; e_rb = 8'h3C; e_rc = 8'h81; e_rctl = 8'h2A;
    wr(0, 8'h01);
    chk("R3", "drv_oe before soft reset", 32'(drv_oe), 0);
    wr(8'h17, 8'h02);
    model_defaults();
    @(negedge clk);
    chk("R6", "drv_oe after soft reset", 32'(drv_oe), 1);
    chk("R6", "cfg_out after soft reset", 32'(cfg_out), 32'hA4A3A2A1);
    rd_chk("R7", 8'h17);
    for (int a = 0; a <= NCFG; a++) rd_chk("R6", a);
    rd_chk("R12", 8'h12); rd_chk("R12", 8'h13); rd_chk("R12", 8'h14); rd_chk("R12", 8'h16);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule